// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block produces effective data addresses for register-indirect loads and stores whose offset comes from a second register. It keeps fifteen 32-bit address registers, loaded through a simple write port. A request names a base register, an index register and an access size. The index is shifted left according to the size, added to the base with a wrapping 32-bit add, and the result is presented on a memory-side stream together with a lane-enable pattern for an 8-byte data path.

Requests enter on a valid/ready stream and results leave on another, one cycle after acceptance. A request is accepted only when the output slot is empty or is being drained in the same cycle, so a stalled memory side back-pressures the requester without losing or altering a held result. A result whose address is not a multiple of its access size never reaches the memory stream; instead the plain `align_fault` output pulses for one cycle while `mem_addr` shows the offending address.

Top module: `agu_scaled_index`

## Requirements
- R1: A register write (`wr_en`, `wr_sel` 0..14) updates the register at the clock edge; a write with `wr_sel` 15 changes nothing, and selecting 15 as base or index reads as zero.
- R2: A request accepted in the same cycle as a write to one of its registers uses the value held before that write.
- R3: The index is shifted left by `req_size` (00 = 1 byte, shift 0; 01 = 2 bytes, shift 1; 10 = 4 bytes, shift 2; 11 = 8 bytes, shift 3), dropping bits above bit 31.
- R4: The address is base plus scaled index modulo 2^32; base 8 with index 0xFFFFFFFF at byte size gives address 7.
- R5: If any of the low `req_size` address bits is set, `align_fault` is high for exactly the cycle after acceptance, `mem_valid` stays low, and `mem_addr` and `mem_size` show the faulting address and size.
- R6: `mem_be` bit k is set for lanes k from `mem_addr[2:0]` up to `mem_addr[2:0]` + bytes - 1, so an aligned result has 1, 2, 4 or 8 contiguous lanes set.
- R7: A result (or fault) appears in the cycle right after the request handshake.
- R8: `req_ready` equals `!mem_valid || mem_ready`; while `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr`, `mem_be` and `mem_size` hold.
- R9: A synchronous reset clears every address register to zero, `mem_valid` and `align_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register written (15 ignored) |
| wr_data | input | 32 | Value written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_base | input | 4 | Base register select |
| req_index | input | 4 | Index register select |
| req_size | input | 2 | Access size code |
| mem_valid | output | 1 | Aligned result present |
| mem_ready | input | 1 | Memory side takes the result |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 8 | Byte lanes of the access |
| mem_size | output | 2 | Access size code of the result |
| align_fault | output | 1 | One-cycle misalignment pulse |

## Verification
The register write port and the address computation can act in one cycle on the same register, and an output stall can coincide with a new request arriving. The bench issues a write and a request naming the written register in the same cycle, then expects the address built from the old value, and a later request proves the new value landed. A memory-ready pattern with long stalls keeps requests waiting while results sit in the slot, and every result is judged both when it first appears (one cycle after its handshake) and when it is taken.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned NUM_REGS = 15;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned LANES    = 8;
  localparam int unsigned LANE_IDX = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
    acc_size_e         size;
    logic              misaligned;
  } agu_result_t;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 15,
  parameter int unsigned SW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] rsel_a,
  input  logic [SW-1:0] rsel_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[g] <= '0;
      else if (we && (wsel == SW'(g)))          regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rsel_a == SW'(i)) rdata_a = regs[i];
      if (rsel_b == SW'(i)) rdata_b = regs[i];
    end
  end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  acc_size_e         size,
  output agu_result_t       res
);
  logic [ADDR_W-1:0]   scaled;
  logic [ADDR_W-1:0]   sum;
  logic [LANE_IDX-1:0] low_mask;
  logic [2*LANES-1:0]  lane_run;
  logic [2*LANES-1:0]  lane_shift;

  always_comb begin
    scaled     = index << size;
    sum        = base + scaled;
    low_mask   = LANE_IDX'((1 << size) - 1);
    lane_run   = (2*LANES)'((1 << (1 << size)) - 1);
    lane_shift = lane_run << sum[LANE_IDX-1:0];
    res.addr       = sum;
    res.size       = size;
    res.lanes      = lane_shift[LANES-1:0];
    res.misaligned = |(sum[LANE_IDX-1:0] & low_mask);
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  agu_result_t in_res,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_fault,
  output agu_result_t out_res
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_res   <= '0;
    end else begin
      out_fault <= take && in_res.misaligned;
      if (take) begin
        out_valid <= !in_res.misaligned;
        out_res   <= in_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/agu_scaled_index.sv
module agu_scaled_index
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_base,
  input  logic [3:0]  req_index,
  input  logic [1:0]  req_size,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [1:0]  mem_size,
  output logic        align_fault
);
  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] index_val;
  agu_result_t       calc_res;
  agu_result_t       held_res;

  agu_regfile #(.DW(ADDR_W), .NREGS(NUM_REGS), .SW(SEL_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .wsel    (wr_sel),
    .wdata   (wr_data),
    .rsel_a  (req_base),
    .rsel_b  (req_index),
    .rdata_a (base_val),
    .rdata_b (index_val)
  );

  agu_addr_calc u_calc (
    .base  (base_val),
    .index (index_val),
    .size  (acc_size_e'(req_size)),
    .res   (calc_res)
  );

  agu_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_res    (calc_res),
    .out_valid (mem_valid),
    .out_ready (mem_ready),
    .out_fault (align_fault),
    .out_res   (held_res)
  );

  assign mem_addr = held_res.addr;
  assign mem_be   = held_res.lanes;
  assign mem_size = held_res.size;
endmodule

// File: rtl/agu_scaled_index_chk.sv
module agu_scaled_index_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [7:0]  mem_be,
  input logic [1:0]  mem_size,
  input logic        align_fault
);
  AST_FAULT_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !mem_valid); // R5

  AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ((mem_addr[2:0] & 3'((1 << mem_size) - 1)) == 3'd0)); // R5

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == (1 << mem_size))); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_size))); // R8

  AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
    req_ready == (!mem_valid || mem_ready)); // R8

  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (rst)
    (!(req_valid && req_ready) && !(mem_valid && !mem_ready)) |=> (!mem_valid && !align_fault)); // R7
endmodule

bind agu_scaled_index agu_scaled_index_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_be      (mem_be),
  .mem_size    (mem_size),
  .align_fault (align_fault)
);

// File: tb/tb_agu_scaled_index.sv
`timescale 1ns/1ps
module tb_agu_scaled_index;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [3:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [3:0] req_base = 0, req_index = 0;
  logic [1:0] req_size = 0;
  logic mem_valid, mem_ready, align_fault;
  logic [31:0] mem_addr;
  logic [7:0] mem_be;
  logic [1:0] mem_size;

  always #2.5 clk = ~clk;

  agu_scaled_index dut (.*);

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  be;
    logic [1:0]  size;
    logic        fault;
    int          acc_cyc;
  } exp_t;

  exp_t q[$];
  logic [31:0] model [16];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit ready_mode = 0; // 0: always ready, 1: stall pattern
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial mem_ready = 1;
  always @(posedge clk) begin
    #1 mem_ready <= ready_mode ? ((cyc % 5) == 0) : 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [3:0] b, input logic [3:0] x, input logic [1:0] s);
    exp_t e;
    logic [31:0] sc;
    logic [15:0] run;
    sc = model[x] << s;
    e.addr = model[b] + sc;
    run = 16'((1 << (1 << s)) - 1) << e.addr[2:0];
    e.be = run[7:0];
    e.size = s;
    e.fault = (e.addr & 32'((1 << s) - 1)) != 0;
    e.acc_cyc = 0;
    return e;
  endfunction

  task automatic write_reg(input logic [3:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (sel != 4'd15) model[sel] = d;
  endtask

  // request, optionally with a write in the same accepted cycle
  task automatic request(input logic [3:0] b, input logic [3:0] x, input logic [1:0] s,
                         input bit with_wr, input logic [3:0] wsel, input logic [31:0] wd);
    exp_t e;
    req_valid = 1; req_base = b; req_index = x; req_size = s;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (with_wr) begin wr_en = 1; wr_sel = wsel; wr_data = wd; end
    e = predict(b, x, s);
    e.acc_cyc = cyc;
    q.push_back(e);
    @(posedge clk); #1;
    req_valid = 0; wr_en = 0;
    if (with_wr && wsel != 4'd15) model[wsel] = wd;
  endtask

  // monitor
  bit prev_v = 0, prev_r = 0;
  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      check("R8 req_ready rule", {31'd0, req_ready}, {31'd0, (!mem_valid || mem_ready)});
      if (align_fault) begin
        if (q.size() == 0) check("R5 unexpected fault", 1, 0);
        else begin
          e = q.pop_front();
          check("R5 fault flag", 1, {31'd0, e.fault});
          check("R5 fault addr R4", mem_addr, e.addr);
          check("R7 fault latency", cyc, e.acc_cyc + 1);
        end
      end else if (mem_valid) begin
        if (q.size() == 0) check("R8 unexpected valid", 1, 0);
        else begin
          e = q[0];
          if (!(prev_v && !prev_r)) check("R7 latency", cyc, e.acc_cyc + 1);
          if (mem_ready) begin
            e = q.pop_front();
            check("R5 no fault expected", 0, {31'd0, e.fault});
            check("R3 R4 addr", mem_addr, e.addr);
            check("R6 lanes", {24'd0, mem_be}, {24'd0, e.be});
            check("R3 size", {30'd0, mem_size}, {30'd0, e.size});
          end
        end
      end
      prev_v = mem_valid; prev_r = mem_ready;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    check("R9 mem_valid after reset", {31'd0, mem_valid}, 0);
    check("R9 fault after reset", {31'd0, align_fault}, 0);
    check("R9 req_ready after reset", {31'd0, req_ready}, 1);
    @(posedge clk); #1;
    // R9: registers read zero
    request(4'd3, 4'd14, 2'd3, 0, 0, 0);
    // R1 writes
    for (int i = 0; i < 15; i++) write_reg(4'(i), 32'h1000_0000 + 32'(i) * 32'h111);
    write_reg(4'd15, 32'hDEAD_BEEF); // R1 ignored, sel 15 reads 0
    request(4'd15, 4'd15, 2'd0, 0, 0, 0);
    // R4 wrap: base 8, index -1, byte
    write_reg(4'd2, 32'd8);
    write_reg(4'd0, 32'hFFFF_FFFF);
    request(4'd2, 4'd0, 2'd0, 0, 0, 0);
    // R3 scaling for all sizes, index 7
    write_reg(4'd2, 32'h0000_1000);
    write_reg(4'd0, 32'd7);
    for (int s = 0; s < 4; s++) request(4'd2, 4'd0, 2'(s), 0, 0, 0);
    // R3 bits shifted out above 31
    write_reg(4'd5, 32'hF000_0001);
    request(4'd2, 4'd5, 2'd3, 0, 0, 0);
    // R5 misaligned cases, R6 lanes at odd offsets
    write_reg(4'd6, 32'h0000_2003);
    write_reg(4'd7, 32'd0);
    for (int s = 0; s < 4; s++) request(4'd6, 4'd7, 2'(s), 0, 0, 0);
    write_reg(4'd6, 32'h0000_2006);
    for (int s = 0; s < 4; s++) request(4'd6, 4'd7, 2'(s), 0, 0, 0);
    // R2: write and request in the same cycle to base register
    request(4'd2, 4'd0, 2'd2, 1, 4'd2, 32'h0000_8000);
    request(4'd2, 4'd0, 2'd2, 0, 0, 0); // R1 new value now in effect
    // R8 back-pressure with stalls
    ready_mode = 1;
    for (int k = 0; k < 24; k++) begin
      write_reg(4'(k % 15), 32'h0000_4000 + 32'(k) * 32'd24);
      request(4'(k % 15), 4'((k + 3) % 15), 2'(k % 4), (k % 3) == 0, 4'((k + 3) % 15), 32'(k));
    end
    ready_mode = 0;
    repeat (20) @(posedge clk);
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 50000) begin @(posedge clk); wd++; end
    #1;
    if (!done) begin n_chk++; n_bad++; $display("FAIL watchdog expired"); end
    n_chk++;
    if (q.size() != 0) begin n_bad++; $display("FAIL R7 results missing actual=%0d expected=0", q.size()); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule